// File: doc/BRIEF.md
# Power-Safe Flash Update Sequencer

This block steps a flash controller through the erase and program operations of two kinds of non-volatile update. A table update erases one page and then programs two rows in it: the new table, then a validity flag. A block update is made safe against power loss. It erases a reserved staging page and copies the payload into two rows of that page. It then programs a progress marker into the same page. Only after that does it erase the two target pages and program them from the staging copy. Last, it clears the marker. After a reset, firmware that finds the marker still set knows that a rewrite was cut short, and it can redo the rewrite from the staging page.

For the whole time an update runs, the block raises a clock-stretch request toward the I2C target engine, so the host is held off while the flash is unavailable. Each step is issued as a level request. It stays up until the flash controller returns a one-cycle done pulse. A per-step watchdog bounds each erase to 20 ms and each program to 2 ms, counted in ticks of the block clock. If a step overruns its limit, the update is aborted and an error is flagged. The worst cases add up to 24 ms for a table update and 72 ms for a block update, and an elaboration check holds the parameters to those totals. A start request that arrives while an update is running is refused with a busy pulse.

Top module: `flash_upd_seq`

## Requirements
- R1: After reset the block is idle: `cmd_req_o`, `scl_stretch_o`, `done_o`, `err_o` and `busy_rej_o` are low, and `cmd_op_o`, `cmd_page_o`, `cmd_row_o` and `cmd_src_o` are zero. While idle, these outputs keep the same values.
- R2: A start request with `kind_i`=0 (table) issues three steps, in this order:
  - erase `tbl_page_i` (op code 1);
  - program row 0 of that page from source 0 (payload);
  - program row 1 of that page from source 1 (flag).

  Op code 2 means program.
- R3: A start request with `kind_i`=1 (block) issues nine steps, in this order:
  - erase page CBUF_PAGE;
  - program CBUF_PAGE rows 0 and 1 from source 0;
  - program CBUF_PAGE row MARK_ROW from source 2 (marker set);
  - erase `tgt_page_i`, then erase `tgt_page_i`+1 (modulo the page count);
  - program row 0 of each of those two pages, in the same order, from source 4 (staging copy);
  - program CBUF_PAGE row MARK_ROW from source 3 (marker clear).
- R4: In a block update, the marker-set step completes before any target page is erased. The marker-clear step is issued only after both target rows have been programmed.
- R5: `scl_stretch_o` is high from the cycle after the accepted start until the edge at which the last step's done is taken, or until an abort.
- R6: A step is left only on a `fl_done_i` pulse. Until then, the op, page, row and source outputs hold steady.
- R7: If no done arrives within ERASE_MS*TICKS_PER_MS cycles for an erase step, or within PROG_MS*TICKS_PER_MS cycles for a program step, the update aborts. On the next cycle `err_o` pulses for one cycle, the request and stretch outputs fall, and `done_o` stays low. A done in the last allowed cycle is still accepted.
- R8: `done_o` pulses for exactly one cycle, in the cycle after the final step's done is taken.
- R9: A start request while an update is running pulses `busy_rej_o` in the next cycle and does not change the running sequence.
- R10: `fl_done_i` pulses while idle have no effect on any output.
- R11: After a completed or aborted update, a new start request is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request (one cycle) |
| kind_i | input | 1 | Update type: 0 table, 1 block |
| tbl_page_i | input | PAGE_W | Page that holds the table |
| tgt_page_i | input | PAGE_W | First of the two block target pages |
| fl_done_i | input | 1 | Step-complete pulse from the flash controller |
| cmd_req_o | output | 1 | Step request to the flash controller, held until done |
| cmd_op_o | output | 2 | 0 none, 1 erase page, 2 program row |
| cmd_page_o | output | PAGE_W | Page addressed by the step |
| cmd_row_o | output | ROW_W | Row addressed by a program step |
| cmd_src_o | output | 3 | Program data source: 0 payload, 1 flag, 2 marker set, 3 marker clear, 4 staging copy |
| scl_stretch_o | output | 1 | Clock-stretch request to the I2C engine |
| done_o | output | 1 | Update finished (one cycle) |
| err_o | output | 1 | Update aborted by the step watchdog (one cycle) |
| busy_rej_o | output | 1 | Start refused because an update was running (one cycle) |

## Verification
Both update kinds are run with several flash response latencies: immediate done, short delays, and done in exactly the last cycle the watchdog allows. These runs separate a correct step order and hold behaviour from off-by-one errors in the step index or the limit. Latencies one cycle past the limit, on both an erase step and a program step, show that an abort happens at the right cycle, that the error pulse is the only pulse produced, and that the next start works. A start request injected mid-update, done pulses sent while idle, and a target page that wraps onto the staging page check that the refusal and ignore paths leave the running sequence and the outputs untouched.

// File: rtl/flash_upd_pkg.sv
package flash_upd_pkg;
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_ERASE = 2'd1,
      OP_PROG  = 2'd2
   } fl_op_e;

   typedef enum logic [2:0] {
      SRC_DATA = 3'd0,
      SRC_FLAG = 3'd1,
      SRC_MSET = 3'd2,
      SRC_MCLR = 3'd3,
      SRC_COPY = 3'd4
   } fl_src_e;

   typedef enum logic {
      UPD_TABLE = 1'b0,
      UPD_BLOCK = 1'b1
   } upd_kind_e;

   localparam int TBL_STEPS = 3;
   localparam int BLK_STEPS = 9;
   localparam int TBL_ERASES = 1;
   localparam int TBL_PROGS  = 2;
   localparam int BLK_ERASES = 3;
   localparam int BLK_PROGS  = 6;
endpackage

// File: rtl/flash_upd_steps.sv
module flash_upd_steps
   import flash_upd_pkg::*;
#(
   parameter int PAGE_W    = 6,
   parameter int ROW_W     = 3,
   parameter int IDX_W     = 4,
   parameter int CBUF_PAGE = 63,
   parameter int MARK_ROW  = 2
) (
   input  upd_kind_e         kind,
   input  logic [IDX_W-1:0]  idx,
   input  logic [PAGE_W-1:0] tbl_page,
   input  logic [PAGE_W-1:0] tgt_page,
   output fl_op_e            op,
   output logic [PAGE_W-1:0] page,
   output logic [ROW_W-1:0]  row,
   output fl_src_e           src,
   output logic              last
);
   localparam logic [PAGE_W-1:0] CBUF_P = PAGE_W'(CBUF_PAGE);
   localparam logic [ROW_W-1:0]  MROW   = ROW_W'(MARK_ROW);

   logic [PAGE_W-1:0] tgt_next;
   assign tgt_next = tgt_page + PAGE_W'(1);

   // table update sequence
   fl_op_e            t_op;
   logic [PAGE_W-1:0] t_page;
   logic [ROW_W-1:0]  t_row;
   fl_src_e           t_src;

   always_comb begin
      t_op   = OP_NONE;
      t_page = tbl_page;
      t_row  = '0;
      t_src  = SRC_DATA;
      case (idx)
         IDX_W'(0): t_op = OP_ERASE;
         IDX_W'(1): begin
            t_op  = OP_PROG;
            t_row = ROW_W'(0);
         end
         IDX_W'(2): begin
            t_op  = OP_PROG;
            t_row = ROW_W'(1);
            t_src = SRC_FLAG;
         end
         default: t_op = OP_NONE;
      endcase
   end

   // block update sequence through the staging page
   fl_op_e            b_op;
   logic [PAGE_W-1:0] b_page;
   logic [ROW_W-1:0]  b_row;
   fl_src_e           b_src;

   always_comb begin
      b_op   = OP_NONE;
      b_page = CBUF_P;
      b_row  = '0;
      b_src  = SRC_DATA;
      case (idx)
         IDX_W'(0): b_op = OP_ERASE;
         IDX_W'(1): begin
            b_op  = OP_PROG;
            b_row = ROW_W'(0);
         end
         IDX_W'(2): begin
            b_op  = OP_PROG;
            b_row = ROW_W'(1);
         end
         IDX_W'(3): begin
            b_op  = OP_PROG;
            b_row = MROW;
            b_src = SRC_MSET;
         end
         IDX_W'(4): begin
            b_op   = OP_ERASE;
            b_page = tgt_page;
         end
         IDX_W'(5): begin
            b_op   = OP_ERASE;
            b_page = tgt_next;
         end
         IDX_W'(6): begin
            b_op   = OP_PROG;
            b_page = tgt_page;
            b_src  = SRC_COPY;
         end
         IDX_W'(7): begin
            b_op   = OP_PROG;
            b_page = tgt_next;
            b_src  = SRC_COPY;
         end
         IDX_W'(8): begin
            b_op  = OP_PROG;
            b_row = MROW;
            b_src = SRC_MCLR;
         end
         default: b_op = OP_NONE;
      endcase
   end

   always_comb begin
      if (kind == UPD_BLOCK) begin
         op   = b_op;
         page = b_page;
         row  = b_row;
         src  = b_src;
         last = (idx == IDX_W'(BLK_STEPS - 1));
      end else begin
         op   = t_op;
         page = t_page;
         row  = t_row;
         src  = t_src;
         last = (idx == IDX_W'(TBL_STEPS - 1));
      end
   end
endmodule

// File: rtl/flash_upd_wdog.sv
module flash_upd_wdog #(
   parameter int TICKS_PER_MS = 1000,
   parameter int ERASE_MS     = 20,
   parameter int PROG_MS      = 2,
   parameter bit WDOG_EN      = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic step_clr,
   input  logic is_erase,
   output logic expire
);
   localparam int ERASE_LIM = ERASE_MS * TICKS_PER_MS;
   localparam int PROG_LIM  = PROG_MS * TICKS_PER_MS;
   localparam int CNT_W     = $clog2(ERASE_LIM + 1);

   if (PROG_LIM < 1 || ERASE_LIM < PROG_LIM) begin : g_bad_lim
      $error("flash_upd_wdog: step limits must be positive and erase >= program");
   end

   if (WDOG_EN) begin : g_wdog
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] lim_m1;

      assign lim_m1 = is_erase ? CNT_W'(ERASE_LIM - 1) : CNT_W'(PROG_LIM - 1);

      always_ff @(posedge clk) begin
         if (!rst_n || !run || step_clr) cnt_q <= '0;
         else                            cnt_q <= cnt_q + CNT_W'(1);
      end

      assign expire = run && (cnt_q == lim_m1);
   end else begin : g_nowdog
      assign expire = 1'b0;
   end
endmodule

// File: rtl/flash_upd_seq.sv
module flash_upd_seq
   import flash_upd_pkg::*;
#(
   parameter int PAGE_W       = 6,
   parameter int ROW_W        = 3,
   parameter int CBUF_PAGE    = 63,
   parameter int MARK_ROW     = 2,
   parameter int TICKS_PER_MS = 1000,
   parameter int ERASE_MS     = 20,
   parameter int PROG_MS      = 2,
   parameter int TBL_MAX_MS   = 24,
   parameter int BLK_MAX_MS   = 72,
   parameter bit WDOG_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              kind_i,
   input  logic [PAGE_W-1:0] tbl_page_i,
   input  logic [PAGE_W-1:0] tgt_page_i,
   input  logic              fl_done_i,
   output logic              cmd_req_o,
   output logic [1:0]        cmd_op_o,
   output logic [PAGE_W-1:0] cmd_page_o,
   output logic [ROW_W-1:0]  cmd_row_o,
   output logic [2:0]        cmd_src_o,
   output logic              scl_stretch_o,
   output logic              done_o,
   output logic              err_o,
   output logic              busy_rej_o
);
   localparam int IDX_W = $clog2(BLK_STEPS);
   localparam int TBL_WORST = TBL_ERASES * ERASE_MS + TBL_PROGS * PROG_MS;
   localparam int BLK_WORST = BLK_ERASES * ERASE_MS + BLK_PROGS * PROG_MS;

   // elaboration checks
   if (PAGE_W < 2 || ROW_W < 2) begin : g_bad_width
      $error("flash_upd_seq: PAGE_W and ROW_W must be at least 2");
   end
   if (CBUF_PAGE < 0 || CBUF_PAGE >= (1 << PAGE_W)) begin : g_bad_cbuf
      $error("flash_upd_seq: CBUF_PAGE out of range");
   end
   if (MARK_ROW < 2 || MARK_ROW >= (1 << ROW_W)) begin : g_bad_mrow
      $error("flash_upd_seq: MARK_ROW must lie above the two staging rows");
   end
   if (TBL_WORST > TBL_MAX_MS || BLK_WORST > BLK_MAX_MS) begin : g_bad_budget
      $error("flash_upd_seq: step limits exceed the update time budget");
   end

   logic              busy_q;
   logic [IDX_W-1:0]  idx_q;
   upd_kind_e         kind_q;
   logic [PAGE_W-1:0] tbl_q;
   logic [PAGE_W-1:0] tgt_q;
   logic              done_q;
   logic              err_q;
   logic              rej_q;

   fl_op_e            st_op;
   logic [PAGE_W-1:0] st_page;
   logic [ROW_W-1:0]  st_row;
   fl_src_e           st_src;
   logic              st_last;
   logic              expire_w;

   flash_upd_steps #(
      .PAGE_W    (PAGE_W),
      .ROW_W     (ROW_W),
      .IDX_W     (IDX_W),
      .CBUF_PAGE (CBUF_PAGE),
      .MARK_ROW  (MARK_ROW)
   ) u_steps (
      .kind     (kind_q),
      .idx      (idx_q),
      .tbl_page (tbl_q),
      .tgt_page (tgt_q),
      .op       (st_op),
      .page     (st_page),
      .row      (st_row),
      .src      (st_src),
      .last     (st_last)
   );

   flash_upd_wdog #(
      .TICKS_PER_MS (TICKS_PER_MS),
      .ERASE_MS     (ERASE_MS),
      .PROG_MS      (PROG_MS),
      .WDOG_EN      (WDOG_EN)
   ) u_wdog (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy_q),
      .step_clr (fl_done_i),
      .is_erase (st_op == OP_ERASE),
      .expire   (expire_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         kind_q <= UPD_TABLE;
         tbl_q  <= '0;
         tgt_q  <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         rej_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         rej_q  <= busy_q && start_i;
         if (!busy_q) begin
            if (start_i) begin
               busy_q <= 1'b1;
               idx_q  <= '0;
               kind_q <= upd_kind_e'(kind_i);
               tbl_q  <= tbl_page_i;
               tgt_q  <= tgt_page_i;
            end
         end else if (fl_done_i) begin
            if (st_last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               idx_q  <= '0;
            end else begin
               idx_q <= idx_q + IDX_W'(1);
            end
         end else if (expire_w) begin
            busy_q <= 1'b0;
            err_q  <= 1'b1;
            idx_q  <= '0;
         end
      end
   end

   assign cmd_req_o     = busy_q;
   assign scl_stretch_o = busy_q;
   assign cmd_op_o      = busy_q ? st_op   : OP_NONE;
   assign cmd_page_o    = busy_q ? st_page : '0;
   assign cmd_row_o     = busy_q ? st_row  : '0;
   assign cmd_src_o     = busy_q ? st_src  : SRC_DATA;
   assign done_o        = done_q;
   assign err_o         = err_q;
   assign busy_rej_o    = rej_q;

   // bookkeeping for the marker-ordering checks
   logic       mset_q;
   logic [1:0] tprog_q;
   always_ff @(posedge clk) begin
      if (!rst_n || !busy_q) begin
         mset_q  <= 1'b0;
         tprog_q <= '0;
      end else if (fl_done_i) begin
         if (cmd_src_o == SRC_MSET) mset_q <= 1'b1;
         if (cmd_src_o == SRC_COPY) tprog_q <= tprog_q + 2'd1;
      end
   end

   // R4
   marker_before_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req_o && kind_q == UPD_BLOCK && cmd_op_o == OP_ERASE &&
       cmd_page_o != PAGE_W'(CBUF_PAGE)) |-> mset_q);

   // R4
   marker_clear_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req_o && cmd_src_o == SRC_MCLR) |-> (tprog_q == 2'd2));

   // R5
   stretch_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_stretch_o) |-> (done_o || err_o));

   // R6
   step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req_o && !fl_done_i && !expire_w) |=>
         ($stable(cmd_op_o) && $stable(cmd_page_o) && $stable(cmd_row_o) && $stable(cmd_src_o)));

   // R7
   abort_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!scl_stretch_o && !done_o));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9
   reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_stretch_o && start_i) |=> busy_rej_o);
endmodule

// File: tb/flash_upd_seq_test.sv
module flash_upd_seq_test;
   localparam int PAGE_W = 6;
   localparam int ROW_W  = 3;
   localparam int CBUF   = 63;
   localparam int MROW   = 2;
   localparam int TICKS  = 4;
   localparam int E_LIM  = 20 * TICKS;
   localparam int P_LIM  = 2 * TICKS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic kind = 1'b0;
   logic [PAGE_W-1:0] tbl_pg = '0;
   logic [PAGE_W-1:0] tgt_pg = '0;
   logic fl_done = 1'b0;

   logic              cmd_req;
   logic [1:0]        cmd_op;
   logic [PAGE_W-1:0] cmd_page;
   logic [ROW_W-1:0]  cmd_row;
   logic [2:0]        cmd_src;
   logic              stretch, done, err, rej;

   always #5 clk = ~clk;

   flash_upd_seq #(
      .PAGE_W(PAGE_W), .ROW_W(ROW_W), .CBUF_PAGE(CBUF), .MARK_ROW(MROW),
      .TICKS_PER_MS(TICKS)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .kind_i(kind),
      .tbl_page_i(tbl_pg), .tgt_page_i(tgt_pg), .fl_done_i(fl_done),
      .cmd_req_o(cmd_req), .cmd_op_o(cmd_op), .cmd_page_o(cmd_page),
      .cmd_row_o(cmd_row), .cmd_src_o(cmd_src), .scl_stretch_o(stretch),
      .done_o(done), .err_o(err), .busy_rej_o(rej)
   );

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;

   // reference model state
   int q_op[$], q_pg[$], q_row[$], q_src[$];
   bit m_busy = 0, m_done = 0, m_err = 0, m_rej = 0, m_kind = 0;
   int m_cnt = 0;

   function automatic void push(int op, int pg, int row, int src);
      q_op.push_back(op); q_pg.push_back(pg); q_row.push_back(row); q_src.push_back(src);
   endfunction

   function automatic void clear_q();
      q_op.delete(); q_pg.delete(); q_row.delete(); q_src.delete();
   endfunction

   function automatic void build(bit k, int tp, int gp);
      int g2;
      g2 = (gp + 1) % (1 << PAGE_W);
      clear_q();
      if (!k) begin
         push(1, tp, 0, 0); push(2, tp, 0, 0); push(2, tp, 1, 1);
      end else begin
         push(1, CBUF, 0, 0); push(2, CBUF, 0, 0); push(2, CBUF, 1, 0);
         push(2, CBUF, MROW, 2); push(1, gp, 0, 0); push(1, g2, 0, 0);
         push(2, gp, 0, 4); push(2, g2, 0, 4); push(2, CBUF, MROW, 3);
      end
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_err = 0; m_rej = 0; m_cnt = 0; clear_q();
      end else begin
         m_done = 0; m_err = 0;
         m_rej = m_busy && start;
         if (!m_busy) begin
            if (start) begin
               build(kind, tbl_pg, tgt_pg);
               m_kind = kind; m_busy = 1; m_cnt = 0;
            end
         end else if (fl_done) begin
            void'(q_op.pop_front()); void'(q_pg.pop_front());
            void'(q_row.pop_front()); void'(q_src.pop_front());
            m_cnt = 0;
            if (q_op.size() == 0) begin m_busy = 0; m_done = 1; end
         end else if (m_cnt == ((q_op[0] == 1) ? E_LIM : P_LIM) - 1) begin
            m_busy = 0; m_err = 1; m_cnt = 0; clear_q();
         end else begin
            m_cnt++;
         end
      end
   end

   task automatic chk(bit ok, string req, string what, int act, int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
      end
   endtask

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      string rq;
      int e_op, e_pg, e_row, e_src;
      rq = !m_busy ? "R1/R10" : (m_kind ? "R3" : "R2");
      e_op  = m_busy ? q_op[0]  : 0;
      e_pg  = m_busy ? q_pg[0]  : 0;
      e_row = m_busy ? q_row[0] : 0;
      e_src = m_busy ? q_src[0] : 0;
      chk(cmd_req == m_busy, "R5", "cmd_req", cmd_req, m_busy);
      chk(stretch == m_busy, "R5", "stretch", stretch, m_busy);
      chk(cmd_op == e_op, rq, "op", cmd_op, e_op);
      chk(cmd_page == e_pg, rq, "page", cmd_page, e_pg);
      chk(cmd_row == e_row, rq, "row", cmd_row, e_row);
      chk(cmd_src == e_src, (m_busy && e_src >= 2) ? "R4" : rq, "src", cmd_src, e_src);
      chk(done == m_done, "R8", "done", done, m_done);
      chk(err == m_err, "R7", "err", err, m_err);
      chk(rej == m_rej, "R9", "busy_rej", rej, m_rej);
   end

   // flash controller responder
   bit resp_on = 0;
   int lat_er = 0, lat_pr = 0, wc = 0;
   always @(negedge clk) begin
      if (resp_on) begin
         if (fl_done) begin fl_done = 0; wc = 0; end
         if (cmd_req) begin
            if (wc >= ((cmd_op == 2'd1) ? lat_er : lat_pr)) begin fl_done = 1; wc = 0; end
            else wc++;
         end else wc = 0;
      end
   end

   task automatic go(bit k, int tp, int gp);
      @(negedge clk);
      start = 1; kind = k; tbl_pg = PAGE_W'(tp); tgt_pg = PAGE_W'(gp);
      @(negedge clk);
      start = 0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while ((m_busy || cmd_req) && n < 5000) begin @(negedge clk); n++; end
      repeat (3) @(negedge clk);
   endtask

   // watchdog
   initial begin
      wait (cyc > 150000);
      mismatched++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (4) @(negedge clk);
      rst_n = 1;
      repeat (3) @(negedge clk);
      resp_on = 1;

      // R2 table update, immediate done
      lat_er = 0; lat_pr = 0;
      go(0, 5, 0); wait_idle();
      // R3 block update, short latencies
      lat_er = 3; lat_pr = 2;
      go(1, 0, 10); wait_idle();
      // R7 boundary: done in last allowed cycle
      lat_er = E_LIM - 1; lat_pr = P_LIM - 1;
      go(1, 0, 20); wait_idle();
      go(0, 7, 0); wait_idle();
      // R7 program step overrun on table update
      lat_er = 1; lat_pr = P_LIM;
      go(0, 9, 0); wait_idle();
      // R11 restart after abort; R7 erase overrun on block
      lat_er = E_LIM; lat_pr = 1;
      go(1, 0, 30); wait_idle();
      // R9 start while busy, target wraps onto staging page
      lat_er = 4; lat_pr = 3;
      go(1, 0, 62);
      repeat (30) @(negedge clk);
      start = 1; kind = 0; tbl_pg = 6'd3;
      @(negedge clk);
      start = 0;
      wait_idle();
      // R10 done pulses while idle
      resp_on = 0;
      repeat (3) begin
         @(negedge clk); fl_done = 1;
         @(negedge clk); fl_done = 0;
      end
      repeat (3) @(negedge clk);
      resp_on = 1;
      // R11 new start after ignored dones
      lat_er = 2; lat_pr = 0;
      go(0, 12, 0); wait_idle();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule